// File: doc/BRIEF.md
# Variable-Latency Coprocessor Issue Scoreboard

This block sits between the issue stage of a processor pipeline and an attached programmable function unit. The unit's initiation interval and its result latency are only known once it has been configured. Each cycle the issue stage presents at most one instruction, together with its two source register numbers and their enables. If the instruction targets the function unit, it also presents a destination register number. The block decides whether that instruction may leave the issue stage. It launches accepted unit operations, and it remembers their destinations in order in a small tag queue. When a result comes back, it tells the register file which register to write.

Availability is tracked in a per-register pending map. An accepted unit operation marks its destination pending. The matching writeback clears it. Any instruction that reads a pending register is held. A unit operation whose destination is already pending is also held, so that results can never land out of order on the same register. A two-bit configuration selects how far the unit may vary:
- Launch rate follows the unit's ready signal, or the unit is assumed always ready.
- Completion follows the unit's retire pulses, or completion is timed internally after a configured number of cycles.

Top module: `xsb_issue_ctrl`

## Requirements
- R1: After reset the pending map is all zero, the error flag is low, no writeback is signalled, and an idle issue slot is not stalled.
- R2: When cfg_mode bit 1 is 0 (rate follows the unit), a unit instruction is stalled in every cycle in which fu_ready is low. An accepted unit instruction raises fu_start in its issue cycle.
- R3: An accepted unit instruction sets the pending bit of its destination, visible in pend_map from the next cycle.
- R4: Every writeback raises wb_en for one cycle. wb_dst is the destination of the oldest outstanding operation, and writebacks occur in issue order. The written register's pending bit reads zero from the following cycle.
- R5: Any instruction, unit or not, stalls while an enabled source (rs1 or rs2) is pending. A disabled source never stalls. A dependent read is released in the cycle after the writeback that clears it.
- R6: A unit instruction whose destination is already pending stalls.
- R7: With QDEPTH (4) operations outstanding, a unit instruction stalls. After one writeback, it is accepted in the next cycle.
- R8: A retire event with nothing outstanding produces no writeback and leaves pend_map unchanged. It sets err_flag, which stays high until reset.
- R9: When cfg_mode bit 0 is 1 (fixed latency), fu_retire is ignored. The writeback of an operation launched in cycle t occurs in cycle t+cfg_lat.
- R10: When cfg_mode bit 1 is 1 (fixed rate), fu_ready is ignored, and a unit instruction with no hazard is accepted even while fu_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Bit 1: fixed launch rate; bit 0: fixed latency |
| cfg_lat | input | LW (4) | Result latency in cycles when latency is fixed (1..MAXLAT) |
| iss_valid | input | 1 | Issue slot holds an instruction |
| iss_fu | input | 1 | The instruction targets the function unit |
| iss_dst | input | TW (4) | Destination register of a unit instruction |
| iss_rs1 | input | TW (4) | First source register |
| iss_rs1_en | input | 1 | First source is read |
| iss_rs2 | input | TW (4) | Second source register |
| iss_rs2_en | input | 1 | Second source is read |
| fu_ready | input | 1 | Unit can accept an operation this cycle |
| fu_retire | input | 1 | Unit completed one operation this cycle |
| iss_stall | output | 1 | Hold the issue stage |
| fu_start | output | 1 | Launch the presented operation into the unit |
| wb_en | output | 1 | Write the unit result this cycle |
| wb_dst | output | TW (4) | Register receiving the unit result |
| pend_map | output | NREG (16) | Per-register pending bits |
| err_flag | output | 1 | Sticky: retire seen with nothing outstanding |

## Verification
The bench targets the cycle boundaries where a slip is easy to make.
- It checks a dependent read in the cycle of its writeback and in the cycle after. A design that released the read too early would read a stale register.
- It fills the tag queue and retires one operation. A design with an off-by-one in the full test would either drop a tag or deadlock.
- It sends a retire with an empty queue. A careless design would write back a garbage register or corrupt the pending map.
- In the fixed-latency modes it keeps fu_retire and fu_ready at the opposite level. A design that still honoured them would write back early or stall.

// File: rtl/xsb_pkg.sv
package xsb_pkg;

  // cfg_mode bit 1 set: launch rate fixed (one per cycle), ready ignored
  function automatic logic rate_follows_unit(input logic [1:0] mode);
    return !mode[1];
  endfunction

  // cfg_mode bit 0 set: completion timed internally, retire ignored
  function automatic logic lat_follows_unit(input logic [1:0] mode);
    return !mode[0];
  endfunction

  // next value of a circular pointer over 'depth' slots
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/xsb_tagq.sv
module xsb_tagq #(
  parameter int DEPTH = 4,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [TW-1:0] slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign head_tag = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (push) begin
        slot[wr_ptr] <= push_tag;
        wr_ptr <= PW'(xsb_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      end
      if (pop) rd_ptr <= PW'(xsb_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/xsb_scoreboard.sv
module xsb_scoreboard #(
  parameter int NREG = 16,
  parameter int TW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [TW-1:0]   set_tag,
  input  logic            clr_en,
  input  logic [TW-1:0]   clr_tag,
  output logic [NREG-1:0] pend
);
  logic [NREG-1:0] set_vec, clr_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    assign set_vec[g] = set_en && (set_tag == TW'(g));
    assign clr_vec[g] = clr_en && (clr_tag == TW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/xsb_fixlat.sv
module xsb_fixlat #(
  parameter int MAXLAT = 8,
  parameter int LW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [LW-1:0] lat,
  output logic          tap
);
  logic [MAXLAT-1:0] stage;
  logic [LW-1:0]     sel;

  // clamp the configured latency into 1..MAXLAT
  always_comb begin
    if (lat == '0)               sel = LW'(1);
    else if (lat > LW'(MAXLAT))  sel = LW'(MAXLAT);
    else                         sel = lat;
  end

  always_comb begin
    tap = 1'b0;
    for (int i = 0; i < MAXLAT; i++)
      if (sel == LW'(i + 1)) tap = stage[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[MAXLAT-2:0], launch};
  end
endmodule

// File: rtl/xsb_issue_ctrl.sv
module xsb_issue_ctrl #(
  parameter int NREG   = 16,
  parameter int QDEPTH = 4,
  parameter int MAXLAT = 8,
  localparam int TW    = $clog2(NREG),
  localparam int LW    = $clog2(MAXLAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic [LW-1:0]   cfg_lat,
  input  logic            iss_valid,
  input  logic            iss_fu,
  input  logic [TW-1:0]   iss_dst,
  input  logic [TW-1:0]   iss_rs1,
  input  logic            iss_rs1_en,
  input  logic [TW-1:0]   iss_rs2,
  input  logic            iss_rs2_en,
  input  logic            fu_ready,
  input  logic            fu_retire,
  output logic            iss_stall,
  output logic            fu_start,
  output logic            wb_en,
  output logic [TW-1:0]   wb_dst,
  output logic [NREG-1:0] pend_map,
  output logic            err_flag
);
  // named internal events
  logic unit_can_take, src_hazard, fu_block;
  logic launch_go, fix_tap, retire_evt, wb_fire, stray_retire;
  logic q_full, q_empty;
  logic [TW-1:0] q_head;

  assign unit_can_take = xsb_pkg::rate_follows_unit(cfg_mode) ? fu_ready : 1'b1;
  assign src_hazard    = (iss_rs1_en && pend_map[iss_rs1]) ||
                         (iss_rs2_en && pend_map[iss_rs2]);
  assign fu_block      = iss_fu && (!unit_can_take || q_full || pend_map[iss_dst]);
  assign iss_stall     = iss_valid && (src_hazard || fu_block);
  assign launch_go     = iss_valid && iss_fu && !iss_stall;
  assign fu_start      = launch_go;

  assign retire_evt    = xsb_pkg::lat_follows_unit(cfg_mode) ? fu_retire : fix_tap;
  assign wb_fire       = retire_evt && !q_empty;
  assign stray_retire  = retire_evt && q_empty;
  assign wb_en         = wb_fire;
  assign wb_dst        = q_head;

  xsb_tagq #(.DEPTH(QDEPTH), .TW(TW)) u_tagq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (launch_go),
    .push_tag (iss_dst),
    .pop      (wb_fire),
    .head_tag (q_head),
    .full     (q_full),
    .empty    (q_empty)
  );

  xsb_scoreboard #(.NREG(NREG), .TW(TW)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (launch_go),
    .set_tag (iss_dst),
    .clr_en  (wb_fire),
    .clr_tag (q_head),
    .pend    (pend_map)
  );

  xsb_fixlat #(.MAXLAT(MAXLAT), .LW(LW)) u_fixlat (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch_go && !xsb_pkg::lat_follows_unit(cfg_mode)),
    .lat    (cfg_lat),
    .tap    (fix_tap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            err_flag <= 1'b0;
    else if (stray_retire) err_flag <= 1'b1;
  end
endmodule

// File: rtl/xsb_issue_chk.sv
module xsb_issue_chk #(
  parameter int NREG = 16,
  parameter int TW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_mode,
  input logic            iss_valid,
  input logic            iss_fu,
  input logic [TW-1:0]   iss_dst,
  input logic [TW-1:0]   iss_rs1,
  input logic            iss_rs1_en,
  input logic            fu_ready,
  input logic            iss_stall,
  input logic            fu_start,
  input logic            wb_en,
  input logic [TW-1:0]   wb_dst,
  input logic [NREG-1:0] pend_map,
  input logic            err_flag,
  input logic            retire_evt,
  input logic            q_full,
  input logic            q_empty
);
  // R2
  rate_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_fu && !cfg_mode[1] && !fu_ready |-> iss_stall);
  // R3
  mark_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fu_start |=> pend_map[$past(iss_dst)]);
  // R4
  clear_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !pend_map[$past(wb_dst)]);
  // R5
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_rs1_en && pend_map[iss_rs1] |-> iss_stall);
  // R6
  waw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_fu && pend_map[iss_dst] |-> iss_stall);
  // R7
  queue_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_fu && q_full |-> iss_stall);
  // R8
  stray_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt && q_empty |-> !wb_en);
  // R8
  stray_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt && q_empty |=> err_flag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind xsb_issue_ctrl xsb_issue_chk #(.NREG(NREG), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .iss_valid  (iss_valid),
  .iss_fu     (iss_fu),
  .iss_dst    (iss_dst),
  .iss_rs1    (iss_rs1),
  .iss_rs1_en (iss_rs1_en),
  .fu_ready   (fu_ready),
  .iss_stall  (iss_stall),
  .fu_start   (fu_start),
  .wb_en      (wb_en),
  .wb_dst     (wb_dst),
  .pend_map   (pend_map),
  .err_flag   (err_flag),
  .retire_evt (retire_evt),
  .q_full     (q_full),
  .q_empty    (q_empty)
);

// File: tb/xsb_issue_ctrl_tb.sv
module xsb_issue_ctrl_tb;
  localparam int NREG = 16;
  localparam int TW   = 4;
  localparam int LW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      cfg_mode = 2'b00;
  logic [LW-1:0]   cfg_lat = 4'd3;
  logic            iss_valid = 0, iss_fu = 0, iss_rs1_en = 0, iss_rs2_en = 0;
  logic [TW-1:0]   iss_dst = 0, iss_rs1 = 0, iss_rs2 = 0;
  logic            fu_ready = 1, fu_retire = 0;
  logic            iss_stall, fu_start, wb_en, err_flag;
  logic [TW-1:0]   wb_dst;
  logic [NREG-1:0] pend_map;

  int tests = 0, fails = 0;
  logic [TW-1:0] exp_q [$];

  always #5 clk = ~clk;

  xsb_issue_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_lat(cfg_lat),
    .iss_valid(iss_valid), .iss_fu(iss_fu), .iss_dst(iss_dst),
    .iss_rs1(iss_rs1), .iss_rs1_en(iss_rs1_en), .iss_rs2(iss_rs2), .iss_rs2_en(iss_rs2_en),
    .fu_ready(fu_ready), .fu_retire(fu_retire), .iss_stall(iss_stall), .fu_start(fu_start),
    .wb_en(wb_en), .wb_dst(wb_dst), .pend_map(pend_map), .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected destinations as writebacks appear
  always @(negedge clk) begin
    if (rst_n && wb_en) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected writeback", 32'(wb_dst), 32'hffff);
      else begin
        automatic logic [TW-1:0] e = exp_q.pop_front();
        check(wb_dst == e, "R4 writeback order", 32'(wb_dst), 32'(e));
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    exp_q.delete();
  endtask

  // driver: one issue-slot cycle; caller is at posedge+1
  task automatic try_issue(input bit fu, input int dst, input int rs1, input bit e1,
                           input int rs2, input bit e2, input bit exp_stall, input string req);
    iss_valid = 1; iss_fu = fu; iss_dst = TW'(dst);
    iss_rs1 = TW'(rs1); iss_rs1_en = e1; iss_rs2 = TW'(rs2); iss_rs2_en = e2;
    @(negedge clk);
    check(iss_stall == exp_stall, req, 32'(iss_stall), 32'(exp_stall));
    if (fu && !iss_stall) begin
      check(fu_start == 1'b1, "R2 launch strobe", 32'(fu_start), 1);
      exp_q.push_back(TW'(dst));
    end
    @(posedge clk); #1;
    iss_valid = 0; iss_fu = 0; iss_rs1_en = 0; iss_rs2_en = 0;
  endtask

  task automatic retire_pulse();
    fu_retire = 1;
    @(posedge clk); #1;
    fu_retire = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(pend_map == '0, "R1 pend_map", 32'(pend_map), 0);
    check(err_flag == 0, "R1 err_flag", 32'(err_flag), 0);
    check(wb_en == 0, "R1 wb_en", 32'(wb_en), 0);
    check(iss_stall == 0, "R1 stall", 32'(iss_stall), 0);
    @(posedge clk); #1;

    // R2 rate follows unit ready
    fu_ready = 0;
    try_issue(1, 3, 0, 0, 0, 0, 1, "R2 stall on not ready");
    fu_ready = 1;
    try_issue(1, 3, 0, 0, 0, 0, 0, "R2 accept when ready");
    @(negedge clk);
    check(pend_map[3] == 1, "R3 dst pending", 32'(pend_map), 32'h8);
    @(posedge clk); #1;

    // R5 source hazards
    try_issue(0, 0, 3, 1, 0, 0, 1, "R5 rs1 hazard");
    try_issue(0, 0, 3, 0, 0, 0, 0, "R5 rs1 disabled");
    try_issue(0, 0, 0, 0, 3, 1, 1, "R5 rs2 hazard");
    // R6 destination already pending
    try_issue(1, 3, 0, 0, 0, 0, 1, "R6 waw stall");
    try_issue(1, 5, 0, 0, 0, 0, 0, "R3 second issue");

    // R4 retire: dependent read held in writeback cycle, released after
    fu_retire = 1; iss_valid = 1; iss_rs1 = 3; iss_rs1_en = 1;
    @(negedge clk);
    check(iss_stall == 1, "R5 held in writeback cycle", 32'(iss_stall), 1);
    check(wb_en == 1, "R4 wb_en on retire", 32'(wb_en), 1);
    @(posedge clk); #1; fu_retire = 0;
    @(negedge clk);
    check(iss_stall == 0, "R5 released after writeback", 32'(iss_stall), 0);
    check(pend_map == 16'h0020, "R4 only dst 5 pending", 32'(pend_map), 32'h20);
    @(posedge clk); #1; iss_valid = 0; iss_rs1_en = 0;
    retire_pulse();
    @(negedge clk);
    check(pend_map == '0, "R4 map drained", 32'(pend_map), 0);
    @(posedge clk); #1;

    // R8 stray retire
    retire_pulse();
    @(negedge clk);
    check(err_flag == 1, "R8 err set", 32'(err_flag), 1);
    check(pend_map == '0, "R8 map unchanged", 32'(pend_map), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(err_flag == 1, "R8 err sticky", 32'(err_flag), 1);
    @(posedge clk); #1;

    // R7 queue full
    do_reset();
    try_issue(1, 1, 0, 0, 0, 0, 0, "R7 fill 1");
    try_issue(1, 2, 0, 0, 0, 0, 0, "R7 fill 2");
    try_issue(1, 4, 0, 0, 0, 0, 0, "R7 fill 3");
    try_issue(1, 6, 0, 0, 0, 0, 0, "R7 fill 4");
    try_issue(1, 7, 0, 0, 0, 0, 1, "R7 full stall");
    retire_pulse();
    try_issue(1, 7, 0, 0, 0, 0, 0, "R7 accept after pop");
    for (int k = 0; k < 4; k++) retire_pulse();
    @(negedge clk);
    check(pend_map == '0, "R4 all cleared", 32'(pend_map), 0);
    check(exp_q.size() == 0, "R4 all written back", 32'(exp_q.size()), 0);
    @(posedge clk); #1;

    // R9 + R10: both fixed, handshakes held at the opposite level
    do_reset();
    cfg_mode = 2'b11; cfg_lat = 4'd3; fu_ready = 0; fu_retire = 1;
    try_issue(1, 9, 0, 0, 0, 0, 0, "R10 ready ignored");
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(wb_en == (k == 3), "R9 fixed latency timing", 32'(wb_en), 32'(k == 3));
    end
    @(posedge clk); #1; fu_retire = 0;
    @(negedge clk);
    check(err_flag == 0, "R9 retire ignored", 32'(err_flag), 0);
    check(pend_map == '0, "R9 cleared", 32'(pend_map), 0);
    @(posedge clk); #1;

    // R2 with fixed latency (mode 01), latency 2
    do_reset();
    cfg_mode = 2'b01; cfg_lat = 4'd2; fu_ready = 0;
    try_issue(1, 2, 0, 0, 0, 0, 1, "R2 rate-variable stall");
    fu_ready = 1;
    try_issue(1, 2, 0, 0, 0, 0, 0, "R2 accept");
    for (int k = 1; k <= 2; k++) begin
      @(negedge clk);
      check(wb_en == (k == 2), "R9 latency 2 timing", 32'(wb_en), 32'(k == 2));
    end
    @(posedge clk); #1;

    // R10 with variable latency (mode 10)
    do_reset();
    cfg_mode = 2'b10; fu_ready = 0;
    try_issue(1, 4, 0, 0, 0, 0, 0, "R10 ready ignored, mode 10");
    retire_pulse();
    @(negedge clk);
    check(pend_map == '0, "R4 unit retire mode 10", 32'(pend_map), 0);
    check(exp_q.size() == 0, "R4 queue drained", 32'(exp_q.size()), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule